// File: doc/BRIEF.md
# Two-Level Device Address Translator

This block turns 40-bit device addresses issued by a DMA engine into 64-bit host physical addresses. It holds an on-chip array of translation slots. A run-time partition count splits the array into two regions. The low region maps device pages directly. The high region holds pointers to second-level tables in host memory, each with 512 entries of 64 bits. The top bit of the device address chooses the path: clear for a direct lookup, set for a two-level walk. A walk costs one 64-bit read on the memory port.

Requests arrive on a valid/ready port, and only one translation is in flight at a time. A direct hit or any fault is decided in the cycle the request is taken, and the response appears on the next cycle. A walk moves through three states. In ST_IDLE the block decodes the request and reads the slot. It moves from ST_IDLE to ST_FETCH when it takes an extended request whose first-level slot is valid. It moves from ST_FETCH to ST_WAIT once the memory port accepts the read. It returns from ST_WAIT to ST_IDLE when the read data comes back, and it responds on that same edge. Simple requests, faulting requests and a free cycle all leave the FSM in ST_IDLE.

Software writes slots and the partition count through a register write port. A write that arrives while a walk is running is held in a one-deep buffer and applied once the FSM is back in ST_IDLE. As a result, no translation ever sees a mix of old and new tables.

Top module: `dev_xlate`

## Requirements
- R1: A successful response carries bits 63:12 of the final table entry followed by bits 11:0 of the device address, unchanged. Bits 11:1 of the entry are ignored.
- R2: Address bit 39 clear selects the simple path. The slot index is bits 17:12, which is bits 27:12 masked to the 64-slot count. Any set bit in 38:18 on this path is a fault.
- R3: On the simple path, a slot index at or above the partition count is a fault.
- R4: Address bit 39 set selects the extended path. The first-level index is bits 33:21, and it selects slot (partition count + index). A set bit in 38:34 is a fault. An index at or above (64 − partition count) is a fault.
- R5: An extended walk issues exactly one read. Its address is bits 63:12 of the first-level slot, then address bits 20:12, then three zero bits.
- R6: Bit 0 of a slot or second-level entry marks it valid. A clear bit 0 in the slot or entry used by a translation is a fault. A fault response has rsp_fault=1 and rsp_paddr=0.
- R7: After reset every slot is zero and the partition count is 64. At that point every extended address faults and every simple address faults as unmapped. req_ready and reg_wr_ready are 1, and rsp_valid and mem_req_valid are 0.
- R8: A write with reg_wr_sel=1 sets the partition count from reg_wr_data. A value above 64 is ignored. reg_wr_sel=0 writes the slot at reg_wr_idx.
- R9: One translation at a time. req_ready is low from the end of the accept cycle until the walk finishes. A simple hit, and any fault decided at accept, gives rsp_valid exactly one cycle after the accept edge.
- R10: A register write during a walk is held and applied after the walk ends, so the running walk uses the old value. While the write is held, reg_wr_ready is 0.
- R11: mem_req_valid and mem_req_addr stay stable until mem_req_ready accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request valid |
| req_ready | output | 1 | Translator can take a request |
| req_addr | input | 40 | Device address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 64 | Host physical address (0 on fault) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ready | output | 1 | Write can be taken |
| reg_wr_sel | input | 1 | 0 = slot, 1 = partition count |
| reg_wr_idx | input | 6 | Slot number |
| reg_wr_data | input | 64 | Slot value or partition count |
| mem_req_valid | output | 1 | Second-level read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Second-level entry |

## Verification
The assertions check several port-level rules on every cycle. They check that no request is accepted while a walk is in flight. They check that the read request holds still under back-pressure and is 8-byte aligned. They check that fault responses carry a zero address, that the offset passes through, and that every response traces back to an accept or a completed read. Whether the right slot or table entry was used, whether the partition bounds and high-bit faults are decided correctly, and whether a write during a walk is held and then takes effect can only be shown by the bench scenarios. Those scenarios compare each response, and each walk's read address, against an independent model of the tables.

// File: rtl/dxl_pkg.sv
`timescale 1ns/1ps
package dxl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_e;

    localparam logic WR_SLOT = 1'b0;
    localparam logic WR_PART = 1'b1;
endpackage

// File: rtl/dxl_slot_store.sv
`timescale 1ns/1ps
module dxl_slot_store
    import dxl_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int ENTRY_W   = 64,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               wr_ready,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [CNT_W-1:0]   part_cnt
);
    logic [ENTRY_W-1:0] slot_q [NUM_SLOTS];
    logic [CNT_W-1:0]   part_q;

    logic               pend_q;
    logic               pend_sel_q;
    logic [IDX_W-1:0]   pend_idx_q;
    logic [ENTRY_W-1:0] pend_data_q;

    logic               app_en;
    logic               app_sel;
    logic [IDX_W-1:0]   app_idx;
    logic [ENTRY_W-1:0] app_data;

    assign wr_ready = !pend_q;

    // A held write goes first once the walk is over; fresh writes stall meanwhile.
    always_comb begin
        app_en   = 1'b0;
        app_sel  = pend_sel_q;
        app_idx  = pend_idx_q;
        app_data = pend_data_q;
        if (!hold) begin
            if (pend_q) begin
                app_en = 1'b1;
            end else if (wr_en) begin
                app_en   = 1'b1;
                app_sel  = wr_sel;
                app_idx  = wr_idx;
                app_data = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_sel_q  <= WR_SLOT;
            pend_idx_q  <= '0;
            pend_data_q <= '0;
        end else if (hold && wr_en && !pend_q) begin
            pend_q      <= 1'b1;
            pend_sel_q  <= wr_sel;
            pend_idx_q  <= wr_idx;
            pend_data_q <= wr_data;
        end else if (!hold && pend_q) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slot_q[i] <= '0;
            end
            part_q <= CNT_W'(NUM_SLOTS);
        end else if (app_en) begin
            if (app_sel == WR_SLOT) begin
                slot_q[app_idx] <= app_data;
            end else if (app_data <= ENTRY_W'(NUM_SLOTS)) begin
                part_q <= app_data[CNT_W-1:0];
            end
        end
    end

    assign rd_data  = slot_q[rd_idx];
    assign part_cnt = part_q;
endmodule

// File: rtl/dxl_decode.sv
`timescale 1ns/1ps
module dxl_decode #(
    parameter int ADDR_W     = 40,
    parameter int PAGE_SHIFT = 12,
    parameter int L2_W       = 9,
    parameter int L1_W       = 13,
    parameter int NUM_SLOTS  = 64,
    parameter int IDX_W      = 6,
    parameter int CNT_W      = 7
) (
    input  logic [ADDR_W-1:PAGE_SHIFT] addr_hi,
    input  logic [CNT_W-1:0]           part_cnt,
    output logic                       is_ext,
    output logic [IDX_W-1:0]           slot_idx,
    output logic [L2_W-1:0]            l2_idx,
    output logic                       fault
);
    localparam int FLAG_BIT   = ADDR_W - 1;
    localparam int SIMPLE_TOP = PAGE_SHIFT + IDX_W;
    localparam int EXT_TOP    = PAGE_SHIFT + L2_W + L1_W;
    localparam int CMP_W      = ((L1_W > CNT_W) ? L1_W : CNT_W) + 1;

    logic [L1_W-1:0]  l1_idx;
    logic [IDX_W-1:0] simple_idx;
    logic [CNT_W-1:0] ext_cnt;
    logic [CMP_W-1:0] ext_slot;
    logic             simple_bad;
    logic             ext_bad;
    logic             unused_bits;

    assign is_ext     = addr_hi[FLAG_BIT];
    assign simple_idx = addr_hi[PAGE_SHIFT +: IDX_W];
    assign l1_idx     = addr_hi[PAGE_SHIFT + L2_W +: L1_W];
    assign l2_idx     = addr_hi[PAGE_SHIFT +: L2_W];
    assign ext_cnt    = CNT_W'(NUM_SLOTS) - part_cnt;
    assign ext_slot   = CMP_W'(part_cnt) + CMP_W'(l1_idx);

    assign simple_bad = (|addr_hi[FLAG_BIT-1:SIMPLE_TOP])
                      || (CNT_W'(simple_idx) >= part_cnt);
    assign ext_bad    = (|addr_hi[FLAG_BIT-1:EXT_TOP])
                      || (CMP_W'(l1_idx) >= CMP_W'(ext_cnt));

    assign slot_idx   = is_ext ? ext_slot[IDX_W-1:0] : simple_idx;
    assign fault      = is_ext ? ext_bad : simple_bad;

    assign unused_bits = ^ext_slot[CMP_W-1:IDX_W];
endmodule

// File: rtl/dev_xlate.sv
`timescale 1ns/1ps
module dev_xlate
    import dxl_pkg::*;
#(
    parameter int NUM_SLOTS  = 64,
    parameter int ADDR_W     = 40,
    parameter int ENTRY_W    = 64,
    parameter int L1_W       = 13,
    parameter int L2_W       = 9,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         rsp_valid,
    output logic                         rsp_fault,
    output logic [ENTRY_W-1:0]           rsp_paddr,
    input  logic                         reg_wr_en,
    output logic                         reg_wr_ready,
    input  logic                         reg_wr_sel,
    input  logic [$clog2(NUM_SLOTS)-1:0] reg_wr_idx,
    input  logic [ENTRY_W-1:0]           reg_wr_data,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [ENTRY_W-1:0]           mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [ENTRY_W-1:0]           mem_rsp_data
);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam int PAD_W = PAGE_SHIFT - L2_W;

    walk_state_e              state_q;
    walk_state_e              state_d;
    logic [ENTRY_W-1:0]       mem_addr_q;
    logic [PAGE_SHIFT-1:0]    off_q;

    logic                     accept;
    logic                     dec_ext;
    logic                     dec_fault;
    logic [IDX_W-1:0]         dec_slot;
    logic [L2_W-1:0]          dec_l2;
    logic [ENTRY_W-1:0]       slot_ent;
    logic [CNT_W-1:0]         part_cnt;
    logic                     unused_bits;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = mem_addr_q;

    dxl_slot_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .ENTRY_W   (ENTRY_W),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (state_q != ST_IDLE),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_idx   (reg_wr_idx),
        .wr_data  (reg_wr_data),
        .wr_ready (reg_wr_ready),
        .rd_idx   (dec_slot),
        .rd_data  (slot_ent),
        .part_cnt (part_cnt)
    );

    dxl_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .L2_W       (L2_W),
        .L1_W       (L1_W),
        .NUM_SLOTS  (NUM_SLOTS),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) dec_i (
        .addr_hi  (req_addr[ADDR_W-1:PAGE_SHIFT]),
        .part_cnt (part_cnt),
        .is_ext   (dec_ext),
        .slot_idx (dec_slot),
        .l2_idx   (dec_l2),
        .fault    (dec_fault)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && dec_ext && !dec_fault && slot_ent[0]) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_paddr  <= '0;
            mem_addr_q <= '0;
            off_q      <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        off_q <= req_addr[PAGE_SHIFT-1:0];
                        if (dec_fault || !slot_ent[0]) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b1;
                            rsp_paddr <= '0;
                        end else if (!dec_ext) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= {slot_ent[ENTRY_W-1:PAGE_SHIFT],
                                          req_addr[PAGE_SHIFT-1:0]};
                        end else begin
                            mem_addr_q <= {slot_ent[ENTRY_W-1:PAGE_SHIFT],
                                           dec_l2, {PAD_W{1'b0}}};
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        if (mem_rsp_data[0]) begin
                            rsp_fault <= 1'b0;
                            rsp_paddr <= {mem_rsp_data[ENTRY_W-1:PAGE_SHIFT], off_q};
                        end else begin
                            rsp_fault <= 1'b1;
                            rsp_paddr <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign unused_bits = ^{slot_ent[PAGE_SHIFT-1:1], mem_rsp_data[PAGE_SHIFT-1:1]};
endmodule

// File: rtl/dxl_checker.sv
`timescale 1ns/1ps
module dxl_checker
    import dxl_pkg::*;
#(
    parameter int ENTRY_W    = 64,
    parameter int PAGE_SHIFT = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  rsp_valid,
    input logic                  rsp_fault,
    input logic [ENTRY_W-1:0]    rsp_paddr,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic [ENTRY_W-1:0]    mem_req_addr,
    input logic [PAGE_SHIFT-1:0] off_q,
    input walk_state_e           state_q
);
    AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !req_ready); // R9

    AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(state_q == ST_WAIT))); // R9

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_READ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R5

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_SHIFT-1:0] == off_q)); // R1
endmodule

bind dev_xlate dxl_checker #(
    .ENTRY_W    (ENTRY_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .off_q         (off_q),
    .state_q       (state_q)
);

// File: tb/dev_xlate_tb_top.sv
`timescale 1ns/1ps
module dev_xlate_tb_top;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [63:0] rsp_paddr;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_ready;
    logic        reg_wr_sel = 1'b0;
    logic [5:0]  reg_wr_idx = '0;
    logic [63:0] reg_wr_data = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    dev_xlate #(.NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .reg_wr_en(reg_wr_en), .reg_wr_ready(reg_wr_ready), .reg_wr_sel(reg_wr_sel),
        .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] m_slot [NS];
    int          m_part = NS;

    // Host memory image: computed entries, some invalid.
    function automatic logic [63:0] mem_entry(input logic [63:0] a);
        if (a[5:3] == 3'b111) return 64'h0000_0000_0000_0ABE;
        return {8'h00, a[43:0] ^ 44'hA5C_3E19_7B20, 12'h001};
    endfunction

    logic [63:0] mq_addr = '0;
    logic [63:0] last_maddr = '0;
    int          mlat = 0;
    bit          mbusy = 1'b0;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= ((cyc % 3) != 1);
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            mbusy <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !mbusy) begin
            mbusy      <= 1'b1;
            mq_addr    <= mem_req_addr;
            last_maddr <= mem_req_addr;
            mlat       <= 2;
        end else if (mbusy) begin
            if (mlat == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_entry(mq_addr);
                mbusy         <= 1'b0;
            end else begin
                mlat <= mlat - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [39:0] a, output bit f, output logic [63:0] pa,
                         output bit walk, output logic [63:0] ma);
        logic [63:0] e;
        logic [63:0] d;
        int idx;
        int l1;
        f = 1'b0; pa = '0; walk = 1'b0; ma = '0;
        if (!a[39]) begin
            idx = int'(a[17:12]);
            if (a[38:18] != 0 || idx >= m_part || !m_slot[idx][0]) f = 1'b1;
            else pa = {m_slot[idx][63:12], a[11:0]};
        end else begin
            l1 = int'(a[33:21]);
            if (a[38:34] != 0 || l1 >= NS - m_part) f = 1'b1;
            else begin
                e = m_slot[m_part + l1];
                if (!e[0]) f = 1'b1;
                else begin
                    walk = 1'b1;
                    ma = {e[63:12], a[20:12], 3'b000};
                    d = mem_entry(ma);
                    if (!d[0]) f = 1'b1;
                    else pa = {d[63:12], a[11:0]};
                end
            end
        end
        if (f) pa = '0;
    endtask

    task automatic xlate(input logic [39:0] a, output bit f, output logic [63:0] pa,
                         output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        f  = rsp_fault;
        pa = rsp_paddr;
    endtask

    task automatic wr(input bit sel, input int idx, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_idx  = 6'(idx);
        reg_wr_data = d;
        while (!reg_wr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (!sel) m_slot[idx] = d;
        else if (d <= 64'(NS)) m_part = int'(d);
    endtask

    task automatic run(input logic [39:0] a, input string tag);
        bit ef, f, walk;
        logic [63:0] epa, pa, ema;
        int lat;
        model(a, ef, epa, walk, ema);
        xlate(a, f, pa, lat);
        check(f == ef, tag, "fault", 64'(f), 64'(ef));
        check(pa == epa, tag, "paddr", pa, epa);
        if (walk) check(last_maddr == ema, "R5 R11", "table read addr", last_maddr, ema);
        else check(lat == 1, "R9", "response latency", 64'(lat), 64'd1);
    endtask

    function automatic logic [39:0] simple_addr(input int idx, input int off);
        return {1'b0, 21'h0, 6'(idx), 12'(off)};
    endfunction

    function automatic logic [39:0] ext_addr(input int l1, input int l2, input int off);
        return {1'b1, 5'h0, 13'(l1), 9'(l2), 12'(off)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", n_chk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit f;
        logic [63:0] pa, exp_pa, exp_ma;
        bit ef, walk;
        int lat;
        logic [39:0] a;
        void'($urandom(32'd24680));
        for (int i = 0; i < NS; i++) m_slot[i] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check(req_ready == 1'b1, "R7", "req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R7", "rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_req_valid == 1'b0, "R7", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        check(reg_wr_ready == 1'b1, "R7", "reg_wr_ready", 64'(reg_wr_ready), 64'd1);
        run(ext_addr(0, 3, 12'h010), "R7");
        run(simple_addr(3, 12'h044), "R7");

        // R1 R2: direct hit, junk in entry bits 11:1
        wr(0, 5, 64'h0000_1234_5678_9FFF);
        run(simple_addr(5, 12'hABC), "R1");
        a = simple_addr(5, 12'h001);
        a[30] = 1'b1;
        run(a, "R2");
        wr(0, 0, 64'h0000_0000_0000_0000);
        run(simple_addr(0, 0), "R6");

        // Build tables with a 40/24 split
        wr(1, 0, 64'd40);
        for (int i = 0; i < NS; i++) begin
            if (i % 7 == 3) wr(0, i, 64'h0);
            else wr(0, i, {$urandom, $urandom} | 64'h1);
        end
        run(simple_addr(39, 12'h7F0), "R3");
        run(simple_addr(40, 12'h7F0), "R3");
        run(ext_addr(23, 9'h1A0, 12'h321), "R4");
        run(ext_addr(24, 0, 0), "R4");
        a = ext_addr(1, 2, 3);
        a[34] = 1'b1;
        run(a, "R4");
        run(ext_addr(0, 9'h007, 12'h555), "R6");

        // R8: out-of-range partition count ignored
        wr(1, 0, 64'd100);
        run(simple_addr(39, 12'h004), "R8");
        run(simple_addr(45, 12'h004), "R8");
        run(ext_addr(5, 9'h011, 12'h0F0), "R8");

        // R10: write to the walking slot is held until the walk ends
        wr(0, m_part + 2, 64'h0000_0012_3456_7001);
        a = ext_addr(2, 5, 12'h123);
        model(a, ef, exp_pa, walk, exp_ma);
        fork
            xlate(a, f, pa, lat);
            begin
                @(negedge clk);
                @(negedge clk);
                reg_wr_en   = 1'b1;
                reg_wr_sel  = 1'b0;
                reg_wr_idx  = 6'(m_part + 2);
                reg_wr_data = 64'h0000_00AB_CDE0_0001;
                @(negedge clk);
                reg_wr_en = 1'b0;
                check(reg_wr_ready == 1'b0, "R10", "write held during walk",
                      64'(reg_wr_ready), 64'd0);
            end
        join
        check(pa == exp_pa && f == ef, "R10", "walk used old slot", pa, exp_pa);
        m_slot[m_part + 2] = 64'h0000_00AB_CDE0_0001;
        run(a, "R10");

        // Random mix
        for (int k = 0; k < 160; k++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 3) begin
                run(simple_addr(int'($urandom % 64), int'($urandom)), "R3");
            end else if (r == 3) begin
                a = simple_addr(int'($urandom % 64), int'($urandom));
                a[18 + int'($urandom % 21)] = 1'b1;
                run(a, "R2");
            end else if (r < 7) begin
                run(ext_addr(int'($urandom % 32), int'($urandom), int'($urandom)), "R4");
            end else begin
                a = ext_addr(int'($urandom % 24), int'($urandom), int'($urandom));
                a[34 + int'($urandom % 5)] = 1'b1;
                run(a, "R4");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule